// File: doc/BRIEF.md
# Four-Plane Raster Scanout with Palette

This block produces the pixel stream for a monochrome raster of 592 by 384 pixels. The display panel has two intensity inputs, one for half brightness and one for full brightness. Four one-bit planes share one address space: data, overlay, overlay-data and attribute. Each address holds one word per plane, and only the low nibble of that word carries pixels. The block walks the frame in raster order and reads all four plane nibbles of a word in one access, on a 16-bit bus. It shifts the four pixels out leftmost first. At each pixel it combines the four plane bits into a palette index. The palette turns that index into black, gray or white.

With the attribute plane cleared and the overlay plane set, the visible level follows overlay-data and ignores data. Software can therefore draw a pop-up window over the background without destroying the background. The attribute plane gives inverse video. The palette can be rewritten at run time. The timing totals and sync positions are parameters, so the same block can drive a shortened test raster.

Top module: `plane_scanout`

## Requirements
- R1: While rst_ni is low and immediately after it, blank_o is 1, half_o, full_o, hsync_o and vsync_o are 0, and rd_addr_o is 0.
- R2: Word addresses are read in ascending order, with H_ACT/4 words per line and lines packed back to back. The address moves by one word for each four displayed pixels, and the first word fetched for every frame is word 0.
- R3: Within a plane nibble, bit 3 is shown first and bit 0 last.
- R4: rd_data_i carries plane p in bits [4p+3:4p], with p = 0 data, 1 overlay, 2 overlay-data and 3 attribute. The palette index of a pixel is {attribute, overlay-data, overlay, data}.
- R5: After reset the palette holds, for indices 0 to 15: 0,2,1,1,0,0,2,2,2,0,0,0,2,2,0,0.
- R6: Palette code 0 drives both intensity pins low. Code 1 drives only half_o. Codes 2 and 3 drive only full_o. half_o and full_o are never both high.
- R7: A write with pal_we_i high stores pal_code_i at entry pal_idx_i on that clock edge. Later pixels use the new code, and code 3 shows as white.
- R8: Outside the H_ACT by V_ACT active area, blank_o is 1 and both intensity pins are 0.
- R9: With h and v being the output-aligned pixel and line counts, hsync_o is high exactly when HS_START <= h < HS_END, and vsync_o is high exactly when VS_START <= v < VS_END.
- R10: Each active line emits H_ACT consecutive pixels with no gap at word boundaries. The line period is H_TOT cycles and the frame period is V_TOT lines.
- R11: When attribute is 0 and overlay is 1, the default palette shows white if overlay-data is 1 and gray if it is 0, whatever the data bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_we_i | input | 1 | Palette write strobe |
| pal_idx_i | input | 4 | Palette entry to write |
| pal_code_i | input | 2 | Level code to store |
| rd_addr_o | output | ADDR_W | Word address presented to plane memory |
| rd_data_i | input | 16 | Four plane nibbles, returned one cycle after the address |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | High outside the active area |
| half_o | output | 1 | Half-bright intensity |
| full_o | output | 1 | Full-bright intensity |

## Verification
The assertions check several properties on every cycle. Blanked cycles must stay dark, and the two intensity pins must never be high together. The fetch address must advance by exactly one word per fetch and restart at zero on each frame's first prefetch. Each shifter load must be preceded by a data capture three cycles earlier, and each palette write must land in the chosen entry. Other behaviour needs the bench's scenarios, which compare every active pixel against a model of the plane memory. These cover the pixel order within a nibble, the index formed from the four planes, the default palette contents, the overlay-window effect, and the sync and blank positions measured from the first active pixel. They also cover palette rewrites between frames that store code 3.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int PLANES = 4;
  localparam int NIB_W  = 4;
  localparam int WORD_W = PLANES * NIB_W;

  typedef enum logic [1:0] {
    LVL_BLACK = 2'd0,
    LVL_GRAY  = 2'd1,
    LVL_WHITE = 2'd2,
    LVL_WHITE_ALT = 2'd3
  } lvl_e;

  // entry i at bits [2i+1:2i]
  localparam logic [31:0] PAL_RESET = 32'h0A02_A058;
endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
  parameter int H_ACT    = 592,
  parameter int H_TOT    = 768,
  parameter int V_ACT    = 384,
  parameter int V_TOT    = 400,
  parameter int HS_START = 620,
  parameter int HS_END   = 680,
  parameter int VS_START = 388,
  parameter int VS_END   = 392,
  parameter int ADDR_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              active_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              fetch_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HW    = $clog2(H_TOT + 1);
  localparam int VW    = $clog2(V_TOT + 1);
  localparam int WORDS = (H_ACT / 4) * V_ACT;
  localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACT);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_PRE    = HW'(H_TOT - 4);
  localparam logic [HW-1:0] H_NXT    = HW'(H_ACT - 4);
  localparam logic [HW-1:0] HS_A     = HW'(HS_START);
  localparam logic [HW-1:0] HS_B     = HW'(HS_END);
  localparam logic [VW-1:0] V_ACT_C  = VW'(V_ACT);
  localparam logic [VW-1:0] V_ACT_M1 = VW'(V_ACT - 1);
  localparam logic [VW-1:0] V_LAST   = VW'(V_TOT - 1);
  localparam logic [VW-1:0] VS_A     = VW'(VS_START);
  localparam logic [VW-1:0] VS_B     = VW'(VS_END);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(WORDS - 1);

  logic [HW-1:0]     hcnt_q;
  logic [VW-1:0]     vcnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic h_last, v_last, next_line_act, v_act, grp_start;

  assign h_last        = (hcnt_q == H_LAST);
  assign v_last        = (vcnt_q == V_LAST);
  assign v_act         = (vcnt_q < V_ACT_C);
  assign next_line_act = v_last || (vcnt_q < V_ACT_M1);
  assign grp_start     = (hcnt_q[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= V_LAST;  // start in blanking so line 0 is prefetched
    end else begin
      hcnt_q <= h_last ? '0 : hcnt_q + 1'b1;
      if (h_last) vcnt_q <= v_last ? '0 : vcnt_q + 1'b1;
    end
  end

  assign active_o = v_act && (hcnt_q < H_ACT_C);
  assign hsync_o  = (hcnt_q >= HS_A) && (hcnt_q < HS_B);
  assign vsync_o  = (vcnt_q >= VS_A) && (vcnt_q < VS_B);
  assign load_o   = active_o && grp_start;
  // fetch one word ahead of the group being shifted
  assign fetch_o  = grp_start &&
                    ((v_act && (hcnt_q < H_NXT)) || ((hcnt_q == H_PRE) && next_line_act));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (fetch_o) addr_q <= (addr_q == A_LAST) ? '0 : addr_q + 1'b1;
    else if ((vcnt_q == V_ACT_C) && (hcnt_q == '0)) addr_q <= '0;
  end
  assign addr_o = addr_q;

  AST_FRAME_ADDR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && v_last) |-> (addr_q == '0)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && (addr_q != A_LAST)) |=> (addr_q == $past(addr_q) + 1'b1)); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= A_LAST); // R2
endmodule

// File: rtl/scan_shift.sv
module scan_shift
  import scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [PLANES-1:0] idx_o
);
  logic              cap_q;
  logic [WORD_W-1:0] hold_q, sh_q, src, src_shl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b0;
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      cap_q <= fetch_i;
      if (cap_q) hold_q <= rd_data_i;  // memory answers one cycle after the address
      sh_q <= src_shl;
    end
  end

  assign src = load_i ? hold_q : sh_q;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign idx_o[p] = src[p*NIB_W + NIB_W - 1];
    assign src_shl[p*NIB_W +: NIB_W] = {src[p*NIB_W +: NIB_W-1], 1'b0};
  end

  AST_HOLD_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> $past(cap_q, 3)); // R10
endmodule

// File: rtl/scan_palette.sv
module scan_palette
  import scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PLANES-1:0] wr_idx_i,
  input  logic [1:0]        wr_code_i,
  input  logic [PLANES-1:0] rd_idx_i,
  output logic              half_o,
  output logic              full_o
);
  localparam int ENTRIES = 1 << PLANES;

  logic [1:0] pal_q [ENTRIES];
  lvl_e       lvl;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pal_q[i] <= PAL_RESET[2*i +: 2];
      else if (we_i && (wr_idx_i == PLANES'(i))) pal_q[i] <= wr_code_i;
    end
  end

  assign lvl    = lvl_e'(pal_q[rd_idx_i]);
  assign half_o = (lvl == LVL_GRAY);
  assign full_o = (lvl == LVL_WHITE) || (lvl == LVL_WHITE_ALT);

  AST_PAL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (pal_q[$past(wr_idx_i)] == $past(wr_code_i))); // R7
endmodule

// File: rtl/plane_scanout.sv
module plane_scanout
  import scan_pkg::*;
#(
  parameter int H_ACT    = 592,
  parameter int H_TOT    = 768,
  parameter int V_ACT    = 384,
  parameter int V_TOT    = 400,
  parameter int HS_START = 620,
  parameter int HS_END   = 680,
  parameter int VS_START = 388,
  parameter int VS_END   = 392,
  parameter int ADDR_W   = $clog2((H_ACT / 4) * V_ACT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pal_we_i,
  input  logic [3:0]        pal_idx_i,
  input  logic [1:0]        pal_code_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [15:0]       rd_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic              half_o,
  output logic              full_o
);
  logic active, hs, vs, fetch, load, half_c, full_c;
  logic [PLANES-1:0] idx;

  scan_timing #(
    .H_ACT(H_ACT), .H_TOT(H_TOT), .V_ACT(V_ACT), .V_TOT(V_TOT),
    .HS_START(HS_START), .HS_END(HS_END), .VS_START(VS_START), .VS_END(VS_END),
    .ADDR_W(ADDR_W)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_o(active), .hsync_o(hs), .vsync_o(vs),
    .fetch_o(fetch), .load_o(load), .addr_o(rd_addr_o)
  );

  scan_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_i(fetch), .load_i(load),
    .rd_data_i(rd_data_i), .idx_o(idx)
  );

  scan_palette u_pal (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(pal_we_i), .wr_idx_i(pal_idx_i),
    .wr_code_i(pal_code_i), .rd_idx_i(idx), .half_o(half_c), .full_o(full_c)
  );

  // single output stage keeps pixels and syncs aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_o <= 1'b1;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      half_o  <= 1'b0;
      full_o  <= 1'b0;
    end else begin
      blank_o <= !active;
      hsync_o <= hs;
      vsync_o <= vs;
      half_o  <= active && half_c;
      full_o  <= active && full_c;
    end
  end

  AST_DARK_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (!half_o && !full_o)); // R8
  AST_ONE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_o && full_o)); // R6
endmodule

// File: tb/sim_plane_scanout.sv
`timescale 1ns/1ps
module sim_plane_scanout;
  localparam int H_ACT = 16, H_TOT = 28, V_ACT = 4, V_TOT = 7;
  localparam int HS_START = 18, HS_END = 22, VS_START = 5, VS_END = 6;
  localparam int WPL = H_ACT / 4;
  localparam int WORDS = WPL * V_ACT;
  localparam int AW = $clog2(WORDS);
  localparam int FRAMES = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pal_we = 1'b0;
  logic [3:0] pal_idx = '0;
  logic [1:0] pal_code = '0;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data;
  logic hsync, vsync, blank, half, full;

  always #2.5 clk = ~clk;

  plane_scanout #(
    .H_ACT(H_ACT), .H_TOT(H_TOT), .V_ACT(V_ACT), .V_TOT(V_TOT),
    .HS_START(HS_START), .HS_END(HS_END), .VS_START(VS_START), .VS_END(VS_END)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pal_we_i(pal_we), .pal_idx_i(pal_idx),
    .pal_code_i(pal_code), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank), .half_o(half), .full_o(full)
  );

  logic [15:0] mem [WORDS];
  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  int n_chk = 0, n_fail = 0;
  logic [1:0] pal_m [16];
  string tag = "R4 R5 R6 R2";
  int frame_cnt = 0;
  bit locked = 0;
  int bh = 0, bv = 0, cyc = 0;
  logic [AW-1:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input logic [15:0] w, input int k);
    return pal_m[{w[15-k], w[11-k], w[7-k], w[3-k]}];
  endfunction

  function automatic void pal_default();
    int d[16] = '{0,2,1,1,0,0,2,2,2,0,0,0,2,2,0,0};
    for (int i = 0; i < 16; i++) pal_m[i] = 2'(d[i]);
  endfunction

  task automatic fill_random();
    for (int i = 0; i < WORDS; i++) mem[i] = 16'($urandom);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      finish_run();
    end
    if (rst_ni) begin
      if (!locked && !blank) begin
        locked = 1;
        bh = 0;
        bv = 0;
      end
      if (!locked) begin
        chk(!half && !full, "R8 pre-frame dark", {half, full}, 0);
      end else begin
        automatic bit act = (bh < H_ACT) && (bv < V_ACT);
        automatic bit ehs = (bh >= HS_START) && (bh < HS_END);
        automatic bit evs = (bv >= VS_START) && (bv < VS_END);
        chk(blank == !act, "R8 R10 blank", blank, !act);
        chk(hsync == ehs && vsync == evs, "R9 sync", {hsync, vsync}, {ehs, evs});
        if (act) begin
          automatic logic [1:0] c = exp_code(mem[bv*WPL + bh/4], bh % 4);
          automatic bit eh = (c == 2'd1);
          automatic bit ef = c[1];
          automatic string t = tag;
          if (frame_cnt == 0 && bv == 0) t = "R3 R4";
          if (frame_cnt == 0 && bv == 1) t = "R11";
          chk(half == eh && full == ef, t, {half, full}, {eh, ef});
        end else begin
          chk(!half && !full, "R8 dark", {half, full}, 0);
        end
        bh++;
        if (bh == H_TOT) begin
          bh = 0;
          bv++;
          if (bv == V_ACT) frame_cnt++;
          if (bv == V_TOT) bv = 0;
        end
      end
      if (rd_addr != prev_addr) begin
        chk(rd_addr == prev_addr + 1'b1 || rd_addr == '0, "R2 addr step", rd_addr, prev_addr + 1);
        prev_addr = rd_addr;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    pal_default();
    fill_random();
    for (int i = 0; i < WPL; i++) mem[i] = 16'h0000;
    mem[0] = 16'h0008;  // only first pixel of the frame lit, data plane
    for (int i = WPL; i < 2*WPL; i++) mem[i] = {4'h0, 4'b1010, 4'hF, 4'($urandom)};
    repeat (3) @(negedge clk);
    chk(blank && !half && !full && !hsync && !vsync && rd_addr == '0, "R1 reset",
        {blank, half, full, hsync, vsync}, 5'b10000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(blank && !half && !full && rd_addr == '0, "R1 after reset", {blank, half, full}, 3'b100);
    for (int f = 1; f < FRAMES; f++) begin
      wait (frame_cnt == f);
      @(negedge clk);
      fill_random();
      if (f >= 4) begin
        tag = "R7 R6";
        for (int k = 0; k < 3; k++) begin
          pal_idx = 4'($urandom);
          pal_code = (k == 0) ? 2'd3 : 2'($urandom);
          pal_we = 1'b1;
          @(negedge clk);
          pal_m[pal_idx] = pal_code;
          pal_we = 1'b0;
        end
      end
    end
    wait (frame_cnt == FRAMES);
    finish_run();
  end
endmodule